// File: doc/BRIEF.md
# PCI Host Bridge Configuration and Shadow Decoder

This block is the configuration-space target of a PCI host bridge. A simple byte-wide port carries a function number, an 8-bit register offset and a data byte. Writes are filtered per register: identity bytes and the reserved window cannot be changed, and the command and status bytes keep some bits and force others. Reads are combinational and have no side effects.

Two of the writable registers control shadowing of the upper BIOS area. The 64 KB window at 0xE0000 is split into four 16 KB segments. Each segment has its own enable bit. A shared two-bit mode field picks where reads and where writes of enabled segments go: internal DRAM or the external bus. For any physical address presented, the block reports in the same cycle whether a read and whether a write to that address is served internally.

Top module: `hb_shadow_bridge`

## Requirements
- R1: An access with a function number other than 0 changes no register on write and returns 0xFF on read.
- R2: Writes to the identity bytes at offsets 0x00–0x03, 0x08–0x0C and 0x0E are discarded.
- R3: Writes to offsets 0x10 through 0x4E are discarded, and those bytes read as 0x00.
- R4: A write to offset 0x04 stores (value AND 0x42) OR 0x04. A write to offset 0x05 stores only bit 0 of the value.
- R5: A write to offset 0x06 stores 0x00, and a write to offset 0x07 stores 0x02.
- R6: After reset, offsets 0x00–0x03 read 0x39, 0x10, 0x06, 0x04; 0x04 reads 0x07; 0x06/0x07 read 0x80/0x02; 0x09–0x0B read 0x00, 0x00, 0x06; 0x50–0x53 read 0xBC, 0xFB, 0xAD, 0xFE. Every other offset reads 0x00.
- R7: Any other offset (for example 0x0D, 0x0F, 0x4F, 0x50–0x54) stores the full written byte. The new value is readable after the clock edge that sampled the write strobe.
- R8: Bit 4+n of offset 0x54 enables shadow segment n (n = 0..3). Segment n covers 0xE0000 + n*0x4000 up to 16 KB beyond that.
- R9: For an enabled segment, bits 6:5 of offset 0x53 select the routing as {read_internal, write_internal}: 00 gives {0,1}, 01 gives {0,0}, 10 gives {1,1}, 11 gives {1,0}.
- R10: An address in a segment whose enable bit is clear reports external for both read and write ({0,0}).
- R11: An address outside 0xE0000–0xEFFFF reports {0,0}. The shadow outputs follow the address combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_func | input | 3 | Function number of the config access |
| cfg_addr | input | 8 | Config register offset |
| cfg_wdata | input | 8 | Config write data |
| cfg_wr | input | 1 | Config write strobe, sampled at the rising edge |
| cfg_rdata | output | 8 | Config read data for cfg_func/cfg_addr (combinational) |
| phys_addr | input | ADDR_W | Physical address for the shadow lookup |
| shd_rd_int | output | 1 | 1 when a read of phys_addr goes to internal DRAM |
| shd_wr_int | output | 1 | 1 when a write to phys_addr goes to internal DRAM |

## Verification
The bench builds the block with its defaults: a 20-bit physical address, 16 KB segments and the window based at 0xE0000. With these values every segment boundary and both window edges (0xDFFFF and 0xF0000) can be reached with real addresses. A table walk writes each filtered offset class and reads it back. Directed sequences then program every mode code with different segment enable patterns, so a swapped enable bit, a wrong mode entry or a missing window check gives a visible output difference.

// File: rtl/hb_cfg_pkg.sv
package hb_cfg_pkg;

    localparam int NREG = 256;

    localparam logic [7:0] OFS_CMD_LO = 8'h04;
    localparam logic [7:0] OFS_CMD_HI = 8'h05;
    localparam logic [7:0] OFS_STS_LO = 8'h06;
    localparam logic [7:0] OFS_STS_HI = 8'h07;
    localparam logic [7:0] OFS_MODE   = 8'h53;
    localparam logic [7:0] OFS_SEGEN  = 8'h54;
    localparam logic [7:0] RSV_LO     = 8'h10;
    localparam logic [7:0] RSV_HI     = 8'h4E;

    localparam logic [7:0] CMD_LO_KEEP = 8'h42;
    localparam logic [7:0] CMD_LO_SET  = 8'h04;
    localparam logic [7:0] CMD_HI_KEEP = 8'h01;
    localparam logic [7:0] STS_HI_VAL  = 8'h02;

    typedef logic [NREG-1:0][7:0] cfg_image_t;

    typedef struct packed {
        logic       keep;
        logic [7:0] data;
    } wr_filt_t;

    // Per-offset write policy: drop, mask/force, or store as written.
    function automatic wr_filt_t cfg_filter(logic [7:0] ofs, logic [7:0] val);
        wr_filt_t r;
        r.keep = 1'b1;
        r.data = val;
        if (ofs >= RSV_LO && ofs <= RSV_HI) begin
            r.keep = 1'b0;
        end
        case (ofs)
            8'h00, 8'h01, 8'h02, 8'h03,
            8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0E: r.keep = 1'b0;
            OFS_CMD_LO: r.data = (val & CMD_LO_KEEP) | CMD_LO_SET;
            OFS_CMD_HI: r.data = val & CMD_HI_KEEP;
            OFS_STS_LO: r.data = 8'h00;
            OFS_STS_HI: r.data = STS_HI_VAL;
            default:    ;
        endcase
        return r;
    endfunction

    function automatic cfg_image_t reset_image();
        cfg_image_t img;
        img = '0;
        img[8'h00] = 8'h39;
        img[8'h01] = 8'h10;
        img[8'h02] = 8'h06;
        img[8'h03] = 8'h04;
        img[8'h04] = 8'h07;
        img[8'h06] = 8'h80;
        img[8'h07] = 8'h02;
        img[8'h0B] = 8'h06;
        img[8'h50] = 8'hBC;
        img[8'h51] = 8'hFB;
        img[8'h52] = 8'hAD;
        img[8'h53] = 8'hFE;
        return img;
    endfunction

endpackage

// File: rtl/hb_cfg_regfile.sv
module hb_cfg_regfile
    import hb_cfg_pkg::*;
#(
    parameter int FUNC_W = 3,
    parameter int SEG_CNT = 4,
    parameter int MODE_LSB = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FUNC_W-1:0] cfg_func,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              cfg_wr,
    output logic [7:0]        cfg_rdata,
    output logic [1:0]        mode_sel,
    output logic [SEG_CNT-1:0] seg_en
);

    localparam cfg_image_t RST_IMG = reset_image();
    localparam int SEGEN_LSB = 8 - SEG_CNT;

    typedef struct packed {
        cfg_image_t cfg;
    } state_t;

    state_t   st_d, st_q;
    wr_filt_t filt;
    logic     own_func;

    assign own_func = (cfg_func == '0);

    always_comb begin
        st_d = st_q;
        filt = cfg_filter(cfg_addr, cfg_wdata);
        if (cfg_wr && own_func && filt.keep) begin
            st_d.cfg[cfg_addr] = filt.data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg <= RST_IMG;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_rdata = own_func ? st_q.cfg[cfg_addr] : 8'hFF;
    assign mode_sel  = st_q.cfg[OFS_MODE][MODE_LSB+1:MODE_LSB];
    assign seg_en    = st_q.cfg[OFS_SEGEN][7:SEGEN_LSB];

    AST_FOREIGN_FUNC_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_func != '0) |-> (cfg_rdata == 8'hFF)); // R1
    AST_ID_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(st_q.cfg[3:0]) && $stable(st_q.cfg[12:8]) && $stable(st_q.cfg[14])); // R2
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg[RSV_LO] == 8'h00) && (st_q.cfg[RSV_HI] == 8'h00)); // R3
    AST_CMD_BIT2_SET: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cfg[OFS_CMD_LO][2] && (st_q.cfg[OFS_CMD_HI][7:1] == 7'd0)); // R4
    AST_STS_HI_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cfg[OFS_STS_HI] == STS_HI_VAL); // R5

endmodule

// File: rtl/hb_shadow_decode.sv
module hb_shadow_decode #(
    parameter int ADDR_W = 20,
    parameter int SEG_SHIFT = 14,
    parameter int SEG_CNT = 4,
    parameter logic [ADDR_W-1:0] WIN_BASE = 20'hE0000
) (
    input  logic [ADDR_W-1:0]  phys_addr,
    input  logic [1:0]         mode_sel,
    input  logic [SEG_CNT-1:0] seg_en,
    output logic               rd_int,
    output logic               wr_int
);

    localparam int IDX_W   = $clog2(SEG_CNT);
    localparam int WIN_LSB = SEG_SHIFT + IDX_W;

    logic               in_win;
    logic [IDX_W-1:0]   seg_idx;
    logic [SEG_CNT-1:0] seg_hit;
    logic               mode_rd, mode_wr;

    assign in_win  = (phys_addr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]);
    assign seg_idx = phys_addr[WIN_LSB-1:SEG_SHIFT];

    // Mode code to {read internal, write internal}: 00->01, 01->00, 10->11, 11->10
    assign mode_rd = mode_sel[1];
    assign mode_wr = ~mode_sel[0];

    for (genvar g = 0; g < SEG_CNT; g++) begin : g_seg
        assign seg_hit[g] = in_win && (seg_idx == IDX_W'(g)) && seg_en[g];
    end

    assign rd_int = |seg_hit && mode_rd;
    assign wr_int = |seg_hit && mode_wr;

endmodule

// File: rtl/hb_shadow_bridge.sv
module hb_shadow_bridge #(
    parameter int ADDR_W = 20,
    parameter int SEG_SHIFT = 14,
    parameter logic [ADDR_W-1:0] WIN_BASE = 20'hE0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_func,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              cfg_wr,
    output logic [7:0]        cfg_rdata,
    input  logic [ADDR_W-1:0] phys_addr,
    output logic              shd_rd_int,
    output logic              shd_wr_int
);

    localparam int SEG_CNT = 4;
    localparam int WIN_LSB = SEG_SHIFT + $clog2(SEG_CNT);

    logic [1:0]         mode_sel;
    logic [SEG_CNT-1:0] seg_en;

    hb_cfg_regfile #(
        .FUNC_W   (3),
        .SEG_CNT  (SEG_CNT),
        .MODE_LSB (5)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_func  (cfg_func),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_wr    (cfg_wr),
        .cfg_rdata (cfg_rdata),
        .mode_sel  (mode_sel),
        .seg_en    (seg_en)
    );

    hb_shadow_decode #(
        .ADDR_W    (ADDR_W),
        .SEG_SHIFT (SEG_SHIFT),
        .SEG_CNT   (SEG_CNT),
        .WIN_BASE  (WIN_BASE)
    ) u_dec (
        .phys_addr (phys_addr),
        .mode_sel  (mode_sel),
        .seg_en    (seg_en),
        .rd_int    (shd_rd_int),
        .wr_int    (shd_wr_int)
    );

    AST_OUT_OF_WINDOW_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (phys_addr[ADDR_W-1:WIN_LSB] != WIN_BASE[ADDR_W-1:WIN_LSB]) |-> !(shd_rd_int || shd_wr_int)); // R11
    AST_NO_ENABLE_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_en == '0) |-> !(shd_rd_int || shd_wr_int)); // R10
    AST_BOTH_EXT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b01) |-> !(shd_rd_int || shd_wr_int)); // R9

endmodule

// File: tb/hb_shadow_bridge_tb.sv
module hb_shadow_bridge_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_func = '0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_rdata;
    logic [19:0] phys_addr = '0;
    logic        shd_rd_int, shd_wr_int;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hb_shadow_bridge u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_func   (cfg_func),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_wr     (cfg_wr),
        .cfg_rdata  (cfg_rdata),
        .phys_addr  (phys_addr),
        .shd_rd_int (shd_rd_int),
        .shd_wr_int (shd_wr_int)
    );

    // {requirement number, offset, write data, expected readback}
    localparam logic [7:0] VEC [NVEC][4] = '{
        '{8'd2, 8'h00, 8'hAA, 8'h39},   // R2
        '{8'd2, 8'h02, 8'h55, 8'h06},   // R2
        '{8'd2, 8'h08, 8'hFF, 8'h00},   // R2
        '{8'd2, 8'h0B, 8'h00, 8'h06},   // R2
        '{8'd2, 8'h0E, 8'hFF, 8'h00},   // R2
        '{8'd3, 8'h10, 8'hFF, 8'h00},   // R3
        '{8'd3, 8'h4E, 8'h12, 8'h00},   // R3
        '{8'd4, 8'h04, 8'hFF, 8'h46},   // R4
        '{8'd4, 8'h04, 8'h00, 8'h04},   // R4
        '{8'd4, 8'h05, 8'hFF, 8'h01},   // R4
        '{8'd5, 8'h06, 8'hFF, 8'h00},   // R5
        '{8'd5, 8'h07, 8'h00, 8'h02},   // R5
        '{8'd7, 8'h4F, 8'h5A, 8'h5A},   // R7
        '{8'd7, 8'h0F, 8'hC3, 8'hC3},   // R7
        '{8'd7, 8'h0D, 8'h77, 8'h77},   // R7
        '{8'd7, 8'h52, 8'h11, 8'h11},   // R7
        '{8'd7, 8'h50, 8'h00, 8'h00}    // R7
    };

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] fn, input logic [7:0] ofs, input logic [7:0] val);
        @(negedge clk);
        cfg_func = fn; cfg_addr = ofs; cfg_wdata = val; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_check(input string req, input logic [2:0] fn, input logic [7:0] ofs,
                             input logic [7:0] exp);
        cfg_func = fn; cfg_addr = ofs;
        #1;
        chk8(req, cfg_rdata, exp);
    endtask

    task automatic shd_check(input string req, input logic [19:0] a, input logic rd, input logic wr);
        phys_addr = a;
        #1;
        chk8(req, {6'd0, shd_rd_int, shd_wr_int}, {6'd0, rd, wr});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: reset image
        cfg_check("R6", 3'd0, 8'h00, 8'h39);
        cfg_check("R6", 3'd0, 8'h01, 8'h10);
        cfg_check("R6", 3'd0, 8'h02, 8'h06);
        cfg_check("R6", 3'd0, 8'h03, 8'h04);
        cfg_check("R6", 3'd0, 8'h04, 8'h07);
        cfg_check("R6", 3'd0, 8'h06, 8'h80);
        cfg_check("R6", 3'd0, 8'h07, 8'h02);
        cfg_check("R6", 3'd0, 8'h0B, 8'h06);
        cfg_check("R6", 3'd0, 8'h50, 8'hBC);
        cfg_check("R6", 3'd0, 8'h51, 8'hFB);
        cfg_check("R6", 3'd0, 8'h52, 8'hAD);
        cfg_check("R6", 3'd0, 8'h53, 8'hFE);
        cfg_check("R6", 3'd0, 8'h54, 8'h00);
        cfg_check("R6", 3'd0, 8'h0F, 8'h00);
        // R10: no segment enabled after reset
        shd_check("R10", 20'hE0000, 1'b0, 1'b0);

        // R1: foreign function reads 0xFF and its writes do not land
        cfg_check("R1", 3'd1, 8'h50, 8'hFF);
        cfg_write(3'd2, 8'h50, 8'h33);
        cfg_check("R1", 3'd0, 8'h50, 8'hBC);
        cfg_write(3'd7, 8'h54, 8'hF0);
        shd_check("R1", 20'hE0000, 1'b0, 1'b0);

        // Table walk over the write filter classes
        for (int i = 0; i < NVEC; i++) begin
            cfg_write(3'd0, VEC[i][1], VEC[i][2]);
            cfg_check($sformatf("R%0d ofs=%02h", VEC[i][0], VEC[i][1]), 3'd0, VEC[i][1], VEC[i][3]);
        end

        // R8/R9/R10: segments 0 and 2 enabled, mode 00
        cfg_write(3'd0, 8'h54, 8'h50);
        cfg_write(3'd0, 8'h53, 8'h00);
        shd_check("R9", 20'hE0000, 1'b0, 1'b1);
        shd_check("R10", 20'hE4000, 1'b0, 1'b0);
        shd_check("R8", 20'hE8123, 1'b0, 1'b1);
        shd_check("R10", 20'hECFFF, 1'b0, 1'b0);
        shd_check("R8", 20'hE3FFF, 1'b0, 1'b1);
        // R9: other modes
        cfg_write(3'd0, 8'h53, 8'h20);
        shd_check("R9", 20'hE0000, 1'b0, 1'b0);
        cfg_write(3'd0, 8'h53, 8'h40);
        shd_check("R9", 20'hE0000, 1'b1, 1'b1);
        cfg_write(3'd0, 8'h53, 8'h60);
        shd_check("R9", 20'hE8000, 1'b1, 1'b0);
        cfg_write(3'd0, 8'h53, 8'h9F);
        shd_check("R9", 20'hE0000, 1'b0, 1'b1);
        // R8: only segment 3 enabled, mode 10
        cfg_write(3'd0, 8'h54, 8'h80);
        cfg_write(3'd0, 8'h53, 8'h40);
        shd_check("R8", 20'hEC000, 1'b1, 1'b1);
        shd_check("R8", 20'hEFFFF, 1'b1, 1'b1);
        shd_check("R10", 20'hE0000, 1'b0, 1'b0);
        shd_check("R10", 20'hEBFFF, 1'b0, 1'b0);
        // R8: only segment 1
        cfg_write(3'd0, 8'h54, 8'h2F);
        shd_check("R8", 20'hE4000, 1'b1, 1'b1);
        shd_check("R8", 20'hE8000, 1'b0, 1'b0);
        // R11: window edges with everything enabled
        cfg_write(3'd0, 8'h54, 8'hF0);
        shd_check("R11", 20'hDFFFF, 1'b0, 1'b0);
        shd_check("R11", 20'hF0000, 1'b0, 1'b0);
        shd_check("R11", 20'h6C000, 1'b0, 1'b0);
        shd_check("R11", 20'hEC000, 1'b1, 1'b1);
        // R7: read of 0x54 shows full stored byte
        cfg_check("R7", 3'd0, 8'h54, 8'hF0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule